// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Converter

This block sits in front of an HDMI transmitter. It takes one 24-bit RGB pixel per clock, with 8 bits for each of red, green and blue. A fixed-point BT.709 limited-range matrix turns each pixel into luma and two colour-difference values. The block then halves the chroma horizontally, so each 16-bit output word holds one luma sample and one chroma sample. The chroma sample alternates between Cb and Cr from pixel to pixel.

Horizontal sync, vertical sync and data-enable pass through a pipeline of the same length as the data path, so they stay aligned with the pixels. A bypass input, sampled with each pixel, sends that pixel out as full-width RGB 4:4:4 with no conversion and no decimation. Chroma pairing starts again on every line: the pixel that arrives as data-enable rises is always the Cb member of a new pair.

Top module: `rgb2ycc422`

## Requirements
- R1: `out_de`, `out_hs` and `out_vs` equal `pix_de`, `pix_hs` and `pix_vs` delayed by exactly 3 clock cycles. Output data is aligned with them.
- R2: While `out_de` is low, `out_data` is all zero.
- R3: In YCbCr mode, `out_data[15:8]` is luma, Y = 16 + floor((47R + 157G + 16B + 128) / 256).
- R4: The per-pixel chroma values are Cb = 128 + floor((112B − 26R − 86G + 128) / 256) and Cr = 128 + floor((112R − 102G − 10B + 128) / 256). These are the values that appear when both pixels of a pair have the same colour.
- R5: Active pixels form pairs. In YCbCr mode, `out_data[7:0]` carries floor((Cb0 + Cb1 + 1) / 2) on the first pixel of a pair and floor((Cr0 + Cr1 + 1) / 2) on the second.
- R6: The pairing phase restarts on every rising edge of `pix_de`, so the first pixel of each line carries Cb.
- R7: If a line ends on the first pixel of a pair, that pixel carries its own Cb, with no averaging.
- R8: When `rgb_bypass` was high with a pixel, the output word is `{R, G, B}`, with R in bits [23:16], G in [15:8] and B in [7:0].
- R9: In YCbCr mode with `out_de` high, bits [23:16] are zero, luma lies in 16..235 and chroma lies in 16..240.
- R10: While reset is active and until the first pixel has passed the pipeline, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_r | input | CW | Red component |
| pix_g | input | CW | Green component |
| pix_b | input | CW | Blue component |
| pix_de | input | 1 | Input data-enable (active pixel) |
| pix_hs | input | 1 | Input horizontal sync |
| pix_vs | input | 1 | Input vertical sync |
| rgb_bypass | input | 1 | Per-pixel RGB 4:4:4 pass-through select |
| out_data | output | 3*CW | Output word: {0, Y, C} or {R, G, B} |
| out_de | output | 1 | Delayed data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |

## Verification
The bench drives lines of random length: single-pixel lines, odd lengths and back-to-back lines with a one-cycle gap. A design that kept its Cb/Cr phase across lines, or that averaged a lone trailing pixel with whatever comes next, would then emit Cr at the start of a line or a polluted Cb. Solid lines of white, black, pure red, pure blue and yellow push luma and chroma to their range limits. A coefficient or rounding error would show as 234, 241 or 15 at those limits. Bypass lines placed between converted lines catch a mode select that is not pipelined with the pixel, and a sync path with the wrong length shows up as a sync offset against the data.

// File: rtl/rgb2ycc422.sv
module rgb2ycc422 #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   pix_r,
  input  logic [CW-1:0]   pix_g,
  input  logic [CW-1:0]   pix_b,
  input  logic            pix_de,
  input  logic            pix_hs,
  input  logic            pix_vs,
  input  logic            rgb_bypass,
  output logic [3*CW-1:0] out_data,
  output logic            out_de,
  output logic            out_hs,
  output logic            out_vs
);
  localparam int SW = CW + 10;
  localparam int FB = 8;
  localparam logic [CW-1:0] Y_OFF = CW'(16 << (CW - 8));
  localparam logic [CW-1:0] C_MID = CW'(128 << (CW - 8));
  localparam logic signed [SW-1:0] RND = SW'(1 << (FB - 1));

  logic signed [SW-1:0] rs, gs, bs, ysum, cbsum, crsum;
  logic [CW-1:0] y_c, cb_c, cr_c;

  assign rs = $signed({{(SW-CW){1'b0}}, pix_r});
  assign gs = $signed({{(SW-CW){1'b0}}, pix_g});
  assign bs = $signed({{(SW-CW){1'b0}}, pix_b});

  assign ysum  = SW'(47) * rs + SW'(157) * gs + SW'(16) * bs + RND;
  assign cbsum = SW'(112) * bs - SW'(26) * rs - SW'(86) * gs + RND;
  assign crsum = SW'(112) * rs - SW'(102) * gs - SW'(10) * bs + RND;

  assign y_c  = CW'(ysum >>> FB) + Y_OFF;
  assign cb_c = CW'(cbsum >>> FB) + C_MID;
  assign cr_c = CW'(crsum >>> FB) + C_MID;

  function automatic logic [CW-1:0] avg2(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{CW{1'b0}}, 1'b1};
    return s[CW:1];
  endfunction

  logic [CW-1:0]   y1, cb1, cr1, y2, cb2, cr2, cr_hold;
  logic [3*CW-1:0] rgb1, rgb2;
  logic            de1, hs1, vs1, byp1, ph1;
  logic            de2, hs2, vs2, byp2, ph2;
  logic            partner;

  // phase of incoming pixel: 0 at line start, then alternating
  always_ff @(posedge clk) begin
    if (rst) begin
      {y1, cb1, cr1, rgb1} <= '0;
      {de1, hs1, vs1, byp1, ph1} <= '0;
    end else begin
      y1   <= y_c;
      cb1  <= cb_c;
      cr1  <= cr_c;
      rgb1 <= {pix_r, pix_g, pix_b};
      de1  <= pix_de;
      hs1  <= pix_hs;
      vs1  <= pix_vs;
      byp1 <= rgb_bypass;
      ph1  <= pix_de && de1 && !ph1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {y2, cb2, cr2, rgb2} <= '0;
      {de2, hs2, vs2, byp2, ph2} <= '0;
    end else begin
      y2   <= y1;
      cb2  <= cb1;
      cr2  <= cr1;
      rgb2 <= rgb1;
      de2  <= de1;
      hs2  <= hs1;
      vs2  <= vs1;
      byp2 <= byp1;
      ph2  <= ph1;
    end
  end

  assign partner = de1 && ph1;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      cr_hold  <= '0;
      {out_de, out_hs, out_vs} <= '0;
    end else begin
      out_de <= de2;
      out_hs <= hs2;
      out_vs <= vs2;
      if (!de2)
        out_data <= '0;
      else if (byp2)
        out_data <= rgb2;
      else if (!ph2) begin
        out_data <= {{CW{1'b0}}, y2, partner ? avg2(cb2, cb1) : cb2};
        cr_hold  <= partner ? avg2(cr2, cr1) : cr2;
      end else
        out_data <= {{CW{1'b0}}, y2, cr_hold};
    end
  end
endmodule

// File: rtl/rgb2ycc422_chk.sv
module rgb2ycc422_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [CW-1:0]   pix_r,
  input logic [CW-1:0]   pix_g,
  input logic [CW-1:0]   pix_b,
  input logic            pix_de,
  input logic            pix_hs,
  input logic            pix_vs,
  input logic            rgb_bypass,
  input logic [3*CW-1:0] out_data,
  input logic            out_de,
  input logic            out_hs,
  input logic            out_vs
);
  localparam logic [CW-1:0] Y_LO = CW'(16 << (CW - 8));
  localparam logic [CW-1:0] Y_HI = CW'(235 << (CW - 8));
  localparam logic [CW-1:0] C_HI = CW'(240 << (CW - 8));

  logic [1:0] settle;
  always_ff @(posedge clk) begin
    if (rst) settle <= '0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  p_sync_delay_r1: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3) |-> ({out_de, out_hs, out_vs} == $past({pix_de, pix_hs, pix_vs}, 3)));

  p_blank_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !out_de |-> (out_data == '0));

  p_bypass_copy_r8: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3 && out_de && $past(rgb_bypass, 3)) |-> (out_data == $past({pix_r, pix_g, pix_b}, 3)));

  p_ycc_range_r9: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3 && out_de && !$past(rgb_bypass, 3)) |->
      (out_data[3*CW-1:2*CW] == '0 &&
       out_data[2*CW-1:CW] >= Y_LO && out_data[2*CW-1:CW] <= Y_HI &&
       out_data[CW-1:0] >= Y_LO && out_data[CW-1:0] <= C_HI));

  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (out_data == '0 && !out_de && !out_hs && !out_vs));
endmodule

bind rgb2ycc422 rgb2ycc422_chk #(.CW(CW)) u_chk (.*);

// File: tb/rgb2ycc422_bench.sv
`timescale 1ns/1ps
module rgb2ycc422_bench;
  localparam int N = 2400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] r = '0, g = '0, b = '0;
  logic de = 1'b0, hs = 1'b0, vs = 1'b0, byp = 1'b0;
  logic [23:0] out_data;
  logic out_de, out_hs, out_vs;

  always #2.5 clk = ~clk;

  rgb2ycc422 u_rgb2ycc422 (
    .clk(clk), .rst(rst), .pix_r(r), .pix_g(g), .pix_b(b),
    .pix_de(de), .pix_hs(hs), .pix_vs(vs), .rgb_bypass(byp),
    .out_data(out_data), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs));

  int ar[N], ag[N], ab[N];
  bit ade[N], ahs[N], avs[N], abyp[N], aph[N];
  int pos = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int fy(int rr, int gg, int bb);
    return 16 + ((47*rr + 157*gg + 16*bb + 128) >>> 8);
  endfunction
  function automatic int fcb(int rr, int gg, int bb);
    return 128 + ((112*bb - 26*rr - 86*gg + 128) >>> 8);
  endfunction
  function automatic int fcr(int rr, int gg, int bb);
    return 128 + ((112*rr - 102*gg - 10*bb + 128) >>> 8);
  endfunction
  function automatic int avg(int a, int c);
    return (a + c + 1) >> 1;
  endfunction

  task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(int rr, int gg, int bb, bit d, bit h, bit v, bit p);
    if (pos < N) begin
      ar[pos] = rr; ag[pos] = gg; ab[pos] = bb;
      ade[pos] = d; ahs[pos] = h; avs[pos] = v; abyp[pos] = p;
      pos++;
    end
  endtask

  // mode 0: random pixels, mode 1: solid colour
  task automatic line(int len, int gap, bit solid, int sr, int sg, int sb, bit p, bit v);
    for (int i = 0; i < gap; i++) put(0, 0, 0, 0, i < 2, v, 0);
    for (int i = 0; i < len; i++) begin
      if (solid) put(sr, sg, sb, 1, 0, 0, p);
      else put(int'($urandom % 256), int'($urandom % 256), int'($urandom % 256), 1, 0, 0, p);
    end
  endtask

  task automatic compare(int idx);
    logic [23:0] exp;
    int y, c;
    string tag;
    bit edx;
    edx = (idx >= 0) ? ade[idx] : 1'b0;
    if (idx < 0) chk("R10", {21'd0, out_de, out_hs, out_vs}, 24'd0);
    else chk("R1", {21'd0, out_de, out_hs, out_vs}, {21'd0, ade[idx], ahs[idx], avs[idx]});
    if (!edx) begin
      chk(idx < 0 ? "R10" : "R2", out_data, 24'd0);
    end else if (abyp[idx]) begin
      chk("R8", out_data, {ar[idx][7:0], ag[idx][7:0], ab[idx][7:0]});
    end else begin
      y = fy(ar[idx], ag[idx], ab[idx]);
      if (!aph[idx]) begin
        if (ade[idx+1] && aph[idx+1]) begin
          c = avg(fcb(ar[idx], ag[idx], ab[idx]), fcb(ar[idx+1], ag[idx+1], ab[idx+1]));
          if (idx == 0 || !ade[idx-1]) tag = "R6";
          else if (fcb(ar[idx], ag[idx], ab[idx]) == fcb(ar[idx+1], ag[idx+1], ab[idx+1])) tag = "R4";
          else tag = "R5";
        end else begin
          c = fcb(ar[idx], ag[idx], ab[idx]);
          tag = "R7";
        end
      end else begin
        c = avg(fcr(ar[idx-1], ag[idx-1], ab[idx-1]), fcr(ar[idx], ag[idx], ab[idx]));
        tag = (fcr(ar[idx-1], ag[idx-1], ab[idx-1]) == fcr(ar[idx], ag[idx], ab[idx])) ? "R4" : "R5";
      end
      exp = {8'd0, y[7:0], c[7:0]};
      chk("R3", {16'd0, out_data[15:8]}, {16'd0, exp[15:8]});
      chk(tag, out_data, exp);
      chk("R9", {23'd0, out_data[23:16] == 0 && out_data[15:8] >= 16 && out_data[15:8] <= 235
                 && out_data[7:0] >= 16 && out_data[7:0] <= 240}, 24'd1);
    end
  endtask

  initial begin
    #(5ns * (N + 2000));
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    // directed corner lines
    line(4, 3, 1, 255, 255, 255, 0, 1);
    line(4, 2, 1, 0, 0, 0, 0, 0);
    line(4, 1, 1, 255, 0, 0, 0, 0);
    line(2, 1, 1, 0, 0, 255, 0, 0);
    line(6, 2, 1, 255, 255, 0, 0, 0);
    line(1, 2, 0, 0, 0, 0, 0, 0);
    line(3, 1, 0, 0, 0, 0, 0, 0);
    line(5, 2, 0, 0, 0, 0, 1, 0);
    line(4, 1, 0, 0, 0, 0, 0, 0);
    while (pos < N - 40)
      line(1 + int'($urandom % 12), 1 + int'($urandom % 4), 0, 0, 0, 0,
           ($urandom % 6) == 0, ($urandom % 10) == 0);
    while (pos < N) put(0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < N; k++)
      aph[k] = (ade[k] && k > 0 && ade[k-1]) ? !aph[k-1] : 1'b0;

    // reset with junk on the inputs
    r = 8'hAA; g = 8'h55; b = 8'hF0; de = 1; hs = 1; vs = 1; byp = 1;
    repeat (3) @(negedge clk);
    chk("R10", {out_data}, 24'd0);
    chk("R10", {21'd0, out_de, out_hs, out_vs}, 24'd0);

    for (int t = 0; t < N + 3; t++) begin
      @(negedge clk);
      if (t > 0) compare(t - 3);
      if (t == 0) rst = 1'b0;
      if (t < N) begin
        r = ar[t][7:0]; g = ag[t][7:0]; b = ab[t][7:0];
        de = ade[t]; hs = ahs[t]; vs = avs[t]; byp = abyp[t];
      end else begin
        r = 0; g = 0; b = 0; de = 0; hs = 0; vs = 0; byp = 0;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule